// File: doc/BRIEF.md
# Compare-Match Watchdog Timer

This block watches for software runaway by counting periodic ticks in a 7-bit up-counter and comparing the next count against a programmable compare value. When the two meet, the block either pulses a CPU reset or raises a sticky interrupt request. A mode input chooses between the two. In interrupt mode the block also works as a plain interval timer: the counter returns to zero on every match, so events repeat every compare-value ticks.

Ticks come from one of two sources, chosen by a select input. The first is a one-cycle strobe from a basic interval timer, already in the system clock domain. The second is an independent free-running oscillator. A prescaler clocked only by that oscillator divides it down. Each division step toggles a flag, and the system domain carries that flag through a synchronizer chain and turns each change into a one-cycle tick. Software programs the compare value through one 8-bit register. Writing a 1 to the top bit of that register asks for a counter restart. The top bit is never stored and always reads back as zero.

Top module: `wdt_match_top`

## Requirements
- R1: After reset, rd_data reads 0x00, irq and wdt_rst are low, and the counter is zero.
- R2: A write stores wr_data[6:0] as the compare value. From the next cycle, rd_data[6:0] returns that value and rd_data[7] reads 0, even right after a write with bit 7 set.
- R3: With src_sel=0 and the counter at zero, a match occurs on the clock edge that samples the Nth bit_tick pulse, for a compare value N from 1 to 127. The match returns the counter to zero, so matches repeat every N ticks.
- R4: A compare value of 0 means 128 ticks. The match occurs when the counter wraps from 127, never on the first tick.
- R5: With mode_rst=0, a match sets irq. irq stays high until a cycle in which irq_ack is sampled high. If a match and irq_ack fall in the same cycle, irq stays set.
- R6: With mode_rst=1, a match drives wdt_rst high for exactly one cycle, the cycle after the edge that sampled the matching tick. irq does not change.
- R7: A write with bit 7 set zeroes the counter on the following clock edge. A tick sampled on that edge is discarded, and counting restarts from zero.
- R8: A write with bit 7 clear changes the compare value without disturbing the counter.
- R9: With src_sel=1, bit_tick has no effect. With src_sel=0, oscillator ticks have no effect.
- R10: With src_sel=1, the counter advances once per 256 osc_clk periods. Matches then repeat every compare-value x 256 oscillator periods, within 3 system cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| osc_clk | input | 1 | Independent free-running oscillator |
| bit_tick | input | 1 | One-cycle tick strobe from the interval timer |
| src_sel | input | 1 | Tick source: 0 interval timer, 1 divided oscillator |
| mode_rst | input | 1 | Match action: 1 reset pulse, 0 interrupt flag |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data: [6:0] compare value, [7] counter restart |
| rd_data | output | 8 | Readback: compare value in [6:0], 0 in [7] |
| irq_ack | input | 1 | Clears the interrupt request flag |
| irq | output | 1 | Sticky interrupt request |
| wdt_rst | output | 1 | One-cycle CPU reset request |

## Verification
The properties assume that bit_tick, wr_en and irq_ack are synchronous one-cycle or level inputs, sampled on the rising edge of clk. They also assume that mode_rst does not change in the same cycle as a matching tick. The stimulus drives every input on the falling edge, and it changes mode_rst and src_sel only when no tick is being delivered. The bench checks oscillator-sourced behaviour only as an interval with a tolerance, because the synchronizer gives the arrival of each tick one cycle of uncertainty. All other cycles are compared exactly against a reference model.

// File: rtl/wdt_match_pkg.sv
package wdt_match_pkg;

   typedef enum logic {
      SRC_INTERVAL = 1'b0,
      SRC_OSC      = 1'b1
   } tick_src_e;

   typedef enum logic {
      ACT_IRQ   = 1'b0,
      ACT_RESET = 1'b1
   } match_act_e;

   // Matching on the incremented value makes a compare value of zero
   // mean a full wrap of the counter.
   function automatic logic next_hits(input logic [15:0] cnt_next,
                                      input logic [15:0] cmp,
                                      input int unsigned width);
      logic [15:0] mask;
      mask = 16'((32'd1 << width) - 32'd1);
      return (cnt_next & mask) == (cmp & mask);
   endfunction

endpackage

// File: rtl/wdt_osc_prescale.sv
module wdt_osc_prescale #(
   parameter int unsigned DIV = 256
) (
   input  logic osc_clk,
   input  logic rst_n,
   output logic step_tgl
);
   localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;

   generate
      if (DIV < 2 || (DIV & (DIV - 1)) != 0) begin : g_bad_div
         $error("wdt_osc_prescale: DIV must be a power of two of at least 2");
      end
   endgenerate

   logic [PW-1:0] div_q;
   logic          tgl_q;

   always_ff @(posedge osc_clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q <= '0;
         tgl_q <= 1'b0;
      end else begin
         div_q <= div_q + 1'b1;
         if (div_q == PW'(DIV - 1)) begin
            tgl_q <= ~tgl_q;
         end
      end
   end

   assign step_tgl = tgl_q;
endmodule

// File: rtl/wdt_tick_sync.sv
module wdt_tick_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tgl_async,
   output logic tick
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wdt_tick_sync: at least two synchronizer stages are required");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= tgl_async;
            end
         end else begin : g_rest
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[s] <= 1'b0;
               else        chain_q[s] <= chain_q[s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign tick = chain_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/wdt_cfg_reg.sv
module wdt_cfg_reg #(
   parameter int unsigned CNT_W   = 7,
   parameter logic [CNT_W-1:0] RESET_CMP = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CNT_W:0]   wr_data,
   output logic [CNT_W-1:0] cmp,
   output logic             clr_req,
   output logic [CNT_W:0]   rd_data
);
   logic [CNT_W-1:0] cmp_q;
   logic             clr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmp_q <= RESET_CMP;
         clr_q <= 1'b0;
      end else begin
         // The restart bit lives for one cycle only.
         clr_q <= wr_en & wr_data[CNT_W];
         if (wr_en) begin
            cmp_q <= wr_data[CNT_W-1:0];
         end
      end
   end

   assign cmp     = cmp_q;
   assign clr_req = clr_q;
   assign rd_data = {1'b0, cmp_q};
endmodule

// File: rtl/wdt_match_core.sv
module wdt_match_core
   import wdt_match_pkg::*;
#(
   parameter int unsigned CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             clr_req,
   input  logic [CNT_W-1:0] cmp,
   input  match_act_e       action,
   input  logic             irq_ack,
   output logic             irq,
   output logic             wdt_rst
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_next;
   logic             hit;
   logic             irq_q;
   logic             rst_q;

   assign cnt_next = cnt_q + 1'b1;
   assign hit      = tick && !clr_req &&
                     next_hits(16'(cnt_next), 16'(cmp), CNT_W);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_req || hit) begin
         cnt_q <= '0;
      end else if (tick) begin
         cnt_q <= cnt_next;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
         rst_q <= 1'b0;
      end else begin
         rst_q <= hit && (action == ACT_RESET);
         if (hit && (action == ACT_IRQ)) begin
            irq_q <= 1'b1;
         end else if (irq_ack) begin
            irq_q <= 1'b0;
         end
      end
   end

   assign irq     = irq_q;
   assign wdt_rst = rst_q;
endmodule

// File: rtl/wdt_match_top.sv
module wdt_match_top
   import wdt_match_pkg::*;
#(
   parameter int unsigned CNT_W       = 7,
   parameter int unsigned OSC_DIV     = 256,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [CNT_W-1:0] RESET_CMP = '0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           osc_clk,
   input  logic           bit_tick,
   input  logic           src_sel,
   input  logic           mode_rst,
   input  logic           wr_en,
   input  logic [CNT_W:0] wr_data,
   output logic [CNT_W:0] rd_data,
   input  logic           irq_ack,
   output logic           irq,
   output logic           wdt_rst
);
   generate
      if (CNT_W < 2 || CNT_W > 15) begin : g_bad_width
         $error("wdt_match_top: CNT_W must lie between 2 and 15");
      end
   endgenerate

   logic             osc_tgl;
   logic             osc_tick;
   logic             tick;
   logic [CNT_W-1:0] cmp;
   logic             clr_req;
   tick_src_e        src;
   match_act_e       action;

   assign src    = tick_src_e'(src_sel);
   assign action = match_act_e'(mode_rst);

   wdt_osc_prescale #(.DIV(OSC_DIV)) u_presc (
      .osc_clk (osc_clk),
      .rst_n   (rst_n),
      .step_tgl(osc_tgl)
   );

   wdt_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .tgl_async(osc_tgl),
      .tick     (osc_tick)
   );

   always_comb begin
      unique case (src)
         SRC_OSC:      tick = osc_tick;
         SRC_INTERVAL: tick = bit_tick;
         default:      tick = 1'b0;
      endcase
   end

   wdt_cfg_reg #(.CNT_W(CNT_W), .RESET_CMP(RESET_CMP)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .cmp    (cmp),
      .clr_req(clr_req),
      .rd_data(rd_data)
   );

   wdt_match_core #(.CNT_W(CNT_W)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .clr_req(clr_req),
      .cmp    (cmp),
      .action (action),
      .irq_ack(irq_ack),
      .irq    (irq),
      .wdt_rst(wdt_rst)
   );
endmodule

// File: rtl/wdt_match_chk.sv
module wdt_match_chk #(
   parameter int unsigned CNT_W = 7
) (
   input logic           clk,
   input logic           rst_n,
   input logic           mode_rst,
   input logic           wr_en,
   input logic [CNT_W:0] wr_data,
   input logic [CNT_W:0] rd_data,
   input logic           irq_ack,
   input logic           irq,
   input logic           wdt_rst
);
   // R6: the reset request never lasts beyond one cycle
   a_r6_rst_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_rst |=> !wdt_rst);

   // R6: a reset request only follows a match taken in reset mode
   a_r6_rst_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wdt_rst) |-> $past(mode_rst));

   // R5: a new interrupt request only follows a match taken in interrupt mode
   a_r5_irq_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> !$past(mode_rst));

   // R5: the request holds until it is acknowledged
   a_r5_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !irq_ack) |=> irq);

   // R2: the written compare value reads back, with the top bit at zero
   a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (rd_data == {1'b0, $past(wr_data[CNT_W-1:0])}));

   // R7: the edge that applies a restart takes no match
   a_r7_restart_no_match: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[CNT_W]) |=> ##1 (!wdt_rst && !$rose(irq)));
endmodule

bind wdt_match_top wdt_match_chk #(.CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .mode_rst(mode_rst),
   .wr_en   (wr_en),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .irq_ack (irq_ack),
   .irq     (irq),
   .wdt_rst (wdt_rst)
);

// File: tb/wdt_match_top_tb.sv
`timescale 1ns/1ps
module wdt_match_top_tb;
   logic       clk = 1'b0;
   logic       osc_clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic       src_sel = 1'b0;
   logic       mode_rst = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic [7:0] rd_data;
   logic       irq_ack = 1'b0;
   logic       irq;
   logic       wdt_rst;

   int checks = 0;
   int failures = 0;
   int cycle = 0;
   bit model_on = 1'b1;
   bit done = 1'b0;

   // behavioural reference model
   int m_cnt = 0;
   int m_cmp = 0;
   bit m_irq = 0;
   bit m_rst = 0;
   bit m_clr = 0;

   always #5  clk = ~clk;
   always #65 osc_clk = ~osc_clk;

   wdt_match_top u_dut (
      .clk(clk), .rst_n(rst_n), .osc_clk(osc_clk), .bit_tick(bit_tick),
      .src_sel(src_sel), .mode_rst(mode_rst), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .irq_ack(irq_ack), .irq(irq), .wdt_rst(wdt_rst)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cycle);
      end
   endtask

   always @(posedge clk) begin
      cycle++;
      if (!rst_n) begin
         m_cnt = 0; m_cmp = 0; m_irq = 0; m_rst = 0; m_clr = 0;
      end else begin
         bit hit;
         int nxt;
         hit = 0;
         if (m_clr) m_cnt = 0;
         else if (!src_sel && bit_tick) begin
            nxt = (m_cnt + 1) % 128;
            if (nxt == m_cmp) begin hit = 1; m_cnt = 0; end
            else m_cnt = nxt;
         end
         m_rst = hit && mode_rst;
         if (hit && !mode_rst) m_irq = 1;
         else if (irq_ack) m_irq = 0;
         m_clr = wr_en && wr_data[7];
         if (wr_en) m_cmp = int'(wr_data[6:0]);
      end
   end

   always @(negedge clk) begin
      if (rst_n && model_on) begin
         chk(irq == m_irq, "R3/R5 model irq", int'(irq), int'(m_irq));
         chk(wdt_rst == m_rst, "R6 model wdt_rst", int'(wdt_rst), int'(m_rst));
         chk(rd_data == {1'b0, 7'(m_cmp)}, "R2 model rd_data", int'(rd_data), m_cmp);
      end
   end

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic write_reg(input logic [7:0] v);
      @(negedge clk);
      wr_en = 1'b1; wr_data = v;
      @(negedge clk);
      wr_en = 1'b0; wr_data = 8'h00;
   endtask

   task automatic ticks(input int n, input int gap);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); bit_tick = 1'b1;
         @(negedge clk); bit_tick = 1'b0;
         idle(gap);
      end
   endtask

   task automatic ack();
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
   endtask

   task automatic wait_irq(output int at);
      at = -1;
      for (int i = 0; i < 20000; i++) begin
         @(negedge clk);
         if (irq) begin at = cycle; break; end
      end
   endtask

   initial begin
      int pulses;
      int t0;
      int t1;
      int t2;
      idle(5);
      @(negedge clk);
      chk(rd_data == 8'h00, "R1 reset rd_data", int'(rd_data), 0);
      chk(irq == 1'b0, "R1 reset irq", int'(irq), 0);
      chk(wdt_rst == 1'b0, "R1 reset wdt_rst", int'(wdt_rst), 0);
      rst_n = 1'b1;
      idle(3);

      // R2 and R3: compare 3, periodic matches on interval ticks
      write_reg(8'h83);
      chk(rd_data == 8'h03, "R2 readback after restart write", int'(rd_data), 3);
      ticks(2, 2);
      chk(irq == 1'b0, "R3 no match before third tick", int'(irq), 0);
      ticks(1, 0);
      chk(irq == 1'b1, "R3 match on third tick", int'(irq), 1);
      ack();
      chk(irq == 1'b0, "R5 acknowledge clears irq", int'(irq), 0);
      ticks(3, 1);
      chk(irq == 1'b1, "R3 match repeats after three more ticks", int'(irq), 1);
      ack();

      // R4: compare 0 means 128 ticks
      write_reg(8'h80);
      ticks(127, 0);
      chk(irq == 1'b0, "R4 no match after 127 ticks", int'(irq), 0);
      ticks(1, 0);
      chk(irq == 1'b1, "R4 match after 128 ticks", int'(irq), 1);

      // R5: match and acknowledge in the same cycle keeps irq set
      write_reg(8'h81);
      @(negedge clk); bit_tick = 1'b1; irq_ack = 1'b1;
      @(negedge clk); bit_tick = 1'b0; irq_ack = 1'b0;
      chk(irq == 1'b1, "R5 set wins over acknowledge", int'(irq), 1);
      ack();

      // R6: reset mode gives one pulse and leaves irq alone
      mode_rst = 1'b1;
      write_reg(8'h82);
      pulses = 0;
      for (int i = 0; i < 2; i++) begin
         @(negedge clk); bit_tick = 1'b1;
         @(negedge clk); bit_tick = 1'b0;
         if (wdt_rst) pulses++;
         for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            if (wdt_rst) pulses++;
         end
      end
      chk(pulses == 1, "R6 single reset pulse", pulses, 1);
      chk(irq == 1'b0, "R6 irq untouched in reset mode", int'(irq), 0);
      mode_rst = 1'b0;
      idle(2);

      // R7: restart discards the tick on its edge
      write_reg(8'h84);
      ticks(3, 0);
      @(negedge clk); wr_en = 1'b1; wr_data = 8'h84;
      @(negedge clk); wr_en = 1'b0; wr_data = 8'h00; bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
      chk(rd_data[7] == 1'b0, "R2 top bit reads zero after restart", int'(rd_data[7]), 0);
      ticks(3, 0);
      chk(irq == 1'b0, "R7 count restarted from zero", int'(irq), 0);
      ticks(1, 0);
      chk(irq == 1'b1, "R7 match four ticks after restart", int'(irq), 1);
      ack();

      // R8: a plain write keeps the count
      write_reg(8'h85);
      ticks(2, 0);
      write_reg(8'h06);
      ticks(3, 0);
      chk(irq == 1'b0, "R8 no match at count five", int'(irq), 0);
      ticks(1, 0);
      chk(irq == 1'b1, "R8 match at count six, count kept", int'(irq), 1);
      ack();

      // R9: interval ticks ignored while the oscillator is selected
      model_on = 1'b0;
      src_sel = 1'b1;
      write_reg(8'h82);
      ticks(5, 0);
      chk(irq == 1'b0, "R9 bit_tick ignored with src_sel=1", int'(irq), 0);

      // R10: oscillator interval, compare 2 -> 2*256*130 ns = 6656 cycles
      ack();
      wait_irq(t0);
      ack();
      wait_irq(t1);
      ack();
      wait_irq(t2);
      ack();
      chk(t1 > 0 && (t1 - t0 >= 6653) && (t1 - t0 <= 6659),
          "R10 oscillator interval one", t1 - t0, 6656);
      chk(t2 > 0 && (t2 - t1 >= 6653) && (t2 - t1 <= 6659),
          "R10 oscillator interval two", t2 - t1, 6656);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      wait (cycle > 150000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", cycle, 150000);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule